// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block gives one processor the hardware half of an atomic read-modify-write on shared memory. Software issues a locked load, changes the value in a register, then issues a conditional store and tests the returned flag. If the flag reads zero, software runs the whole sequence again. The monitor keeps one reservation on the aligned 16-byte block named by the locked load. That reservation is cancelled by an interrupt, by an exception, or by a write from another agent anywhere in the block.

A conditional store is let through to memory only while the reservation is intact and the store falls in the reserved block. Otherwise the write is suppressed. In both cases the outcome comes back as a registered flag one cycle after the store strobe, and the processor never stalls. Addresses and data are 64 bits wide by default.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: After a locked load, a conditional store to any byte of the same aligned 16-byte block (address bits [63:4] equal), with no cancelling event in between, succeeds. One cycle after the store strobe, mem_we_o is 1, mem_addr_o and mem_data_o equal the store's address and data, and sc_ok_o is 1.
- R2: An interrupt pulse between the locked load and the conditional store makes the store fail: mem_we_o stays 0 and sc_ok_o is 0.
- R3: An exception pulse in that interval makes the store fail in the same way.
- R4: A snooped write (snoop_valid_i high) to any address inside the reserved block makes the store fail. A snooped write outside the block does not affect the reservation. An address on the snoop port while snoop_valid_i is low does not affect it either.
- R5: A conditional store whose address lies outside the reserved block fails and writes nothing.
- R6: Every conditional store clears the reservation, whether it succeeds or fails, so a second store with no new locked load fails.
- R7: A new locked load replaces the current reservation. A store to the old block then fails, and a store to the new block succeeds.
- R8: sc_done_o is 1 exactly in the cycle after a cycle with sc_valid_i high. At that point sc_ok_o reads 1 for success and 0 for failure. sc_ok_o keeps its value until the next conditional store.
- R9: A conditional store with no reservation in place fails.
- R10: Events in the same cycle are resolved as follows:
  - An interrupt, an exception or a matching snoop in the cycle of a conditional store makes that store fail.
  - Such an event in the cycle of a locked load means no reservation is set.
  - A store and a locked load in the same cycle: the store is judged against the old reservation, and the load then sets the new one.
- R11: Reset clears the reservation and drives mem_we_o, sc_done_o and sc_ok_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ll_valid_i | input | 1 | Locked-load strobe |
| ll_addr_i | input | 64 | Locked-load address |
| sc_valid_i | input | 1 | Conditional-store strobe |
| sc_addr_i | input | 64 | Conditional-store address |
| sc_data_i | input | 64 | Conditional-store data |
| snoop_valid_i | input | 1 | Write by another agent observed |
| snoop_addr_i | input | 64 | Address of the snooped write |
| irq_i | input | 1 | Interrupt taken |
| exc_i | input | 1 | Exception taken |
| mem_we_o | output | 1 | Gated memory write enable |
| mem_addr_o | output | 64 | Write address |
| mem_data_o | output | 64 | Write data |
| sc_done_o | output | 1 | Conditional-store outcome valid |
| sc_ok_o | output | 1 | Outcome: 1 success, 0 failure |

## Verification
A reservation valid bit that is stuck or not cleared only shows at the next conditional store. That store writes when it should not, or the reverse, on mem_we_o and sc_ok_o one cycle after its strobe. A wrong stored block tag shows the same way, but only when the store address or a snoop address falls in a different block from the locked one. For this reason the stimulus pairs in-block and out-of-block addresses for both stores and snoops. Same-cycle collisions of a store with a load or a cancelling event show a wrong priority within that one cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    SC_PASS     = 2'd0,
    SC_NO_RESV  = 2'd1,
    SC_MISMATCH = 2'd2,
    SC_KILLED   = 2'd3
  } sc_cause_e;

  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned CMP_SNP_RESV = 0;
  localparam int unsigned CMP_SC_RESV  = 1;
  localparam int unsigned CMP_SNP_LL   = 2;
endpackage

// File: rtl/llsc_tag_match.sv
module llsc_tag_match #(
  parameter int unsigned TAG_W = 60
) (
  input  logic [TAG_W-1:0] a_i,
  input  logic [TAG_W-1:0] b_i,
  output logic             hit_o
);
  assign hit_o = (a_i == b_i);
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
  parameter int unsigned TAG_W = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ll_valid_i,
  input  logic [TAG_W-1:0] ll_tag_i,
  input  logic             ll_kill_i,   // cancel event hitting the load cycle
  input  logic             resv_kill_i, // cancel event hitting the held reservation
  input  logic             sc_valid_i,
  output logic             resv_valid_o,
  output logic [TAG_W-1:0] resv_tag_o
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (ll_valid_i) begin
      valid_d = !ll_kill_i;
      tag_d   = ll_tag_i;
    end else if (sc_valid_i || resv_kill_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  assign resv_valid_o = valid_q;
  assign resv_tag_o   = tag_q;
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
  import llsc_pkg::*;
(
  input  logic resv_valid_i,
  input  logic sc_hit_i,
  input  logic kill_now_i,
  output logic pass_o
);
  sc_cause_e cause;

  always_comb begin
    if (!resv_valid_i)   cause = SC_NO_RESV;
    else if (!sc_hit_i)  cause = SC_MISMATCH;
    else if (kill_now_i) cause = SC_KILLED;
    else                 cause = SC_PASS;
  end

  assign pass_o = (cause == SC_PASS);
endmodule

// File: rtl/llsc_write_gate.sv
module llsc_write_gate #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_valid_i,
  input  logic              pass_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [DATA_W-1:0] sc_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              sc_done_o,
  output logic              sc_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      sc_done_o  <= 1'b0;
      sc_ok_o    <= 1'b0;
    end else begin
      sc_done_o <= sc_valid_i;
      mem_we_o  <= sc_valid_i && pass_i;
      if (sc_valid_i) begin
        mem_addr_o <= sc_addr_i;
        mem_data_o <= sc_data_i;
        sc_ok_o    <= pass_i;
      end
    end
  end
endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned BLOCK_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ll_valid_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic [DATA_W-1:0] sc_data_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              irq_i,
  input  logic              exc_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              sc_done_o,
  output logic              sc_ok_o
);
  localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] ll_tag, sc_tag, snp_tag, resv_tag;
  logic             resv_valid;
  logic [TAG_W-1:0] cmp_a [NUM_CMP];
  logic [TAG_W-1:0] cmp_b [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic             snp_hit_resv, snp_hit_ll, kill_now, ll_kill, pass;

  assign ll_tag  = ll_addr_i[ADDR_W-1:OFF_W];
  assign sc_tag  = sc_addr_i[ADDR_W-1:OFF_W];
  assign snp_tag = snoop_addr_i[ADDR_W-1:OFF_W];

  // block offsets never enter the reservation
  logic unused_offsets;
  assign unused_offsets = ^{ll_addr_i[OFF_W-1:0], snoop_addr_i[OFF_W-1:0]};

  always_comb begin
    cmp_a[CMP_SNP_RESV] = snp_tag;  cmp_b[CMP_SNP_RESV] = resv_tag;
    cmp_a[CMP_SC_RESV]  = sc_tag;   cmp_b[CMP_SC_RESV]  = resv_tag;
    cmp_a[CMP_SNP_LL]   = snp_tag;  cmp_b[CMP_SNP_LL]   = ll_tag;
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    llsc_tag_match #(.TAG_W(TAG_W)) u_match (
      .a_i  (cmp_a[g]),
      .b_i  (cmp_b[g]),
      .hit_o(cmp_hit[g])
    );
  end

  assign snp_hit_resv = snoop_valid_i && cmp_hit[CMP_SNP_RESV];
  assign snp_hit_ll   = snoop_valid_i && cmp_hit[CMP_SNP_LL];
  assign kill_now     = irq_i || exc_i || snp_hit_resv;
  assign ll_kill      = irq_i || exc_i || snp_hit_ll;

  llsc_resv_tracker #(.TAG_W(TAG_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ll_valid_i  (ll_valid_i),
    .ll_tag_i    (ll_tag),
    .ll_kill_i   (ll_kill),
    .resv_kill_i (kill_now),
    .sc_valid_i  (sc_valid_i),
    .resv_valid_o(resv_valid),
    .resv_tag_o  (resv_tag)
  );

  llsc_sc_judge u_judge (
    .resv_valid_i(resv_valid),
    .sc_hit_i    (cmp_hit[CMP_SC_RESV]),
    .kill_now_i  (kill_now),
    .pass_o      (pass)
  );

  llsc_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sc_valid_i(sc_valid_i),
    .pass_i    (pass),
    .sc_addr_i (sc_addr_i),
    .sc_data_i (sc_data_i),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o),
    .sc_done_o (sc_done_o),
    .sc_ok_o   (sc_ok_o)
  );
endmodule

// File: rtl/llsc_monitor_checker.sv
module llsc_monitor_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ll_valid_i,
  input logic sc_valid_i,
  input logic irq_i,
  input logic exc_i,
  input logic mem_we_o,
  input logic sc_done_o,
  input logic sc_ok_o
);
  assert_write_needs_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sc_done_o && sc_ok_o));

  assert_irq_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && irq_i) |=> !mem_we_o);

  assert_exc_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && exc_i) |=> !mem_we_o);

  assert_sc_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && !ll_valid_i) ##1 sc_valid_i |=> !mem_we_o);

  assert_done_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_i |=> sc_done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_valid_i |=> !sc_done_o);

  assert_ok_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_valid_i |=> $stable(sc_ok_o));
endmodule

bind llsc_reservation_monitor llsc_monitor_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ll_valid_i(ll_valid_i),
  .sc_valid_i(sc_valid_i),
  .irq_i     (irq_i),
  .exc_i     (exc_i),
  .mem_we_o  (mem_we_o),
  .sc_done_o (sc_done_o),
  .sc_ok_o   (sc_ok_o)
);

// File: tb/llsc_reservation_monitor_tb.sv
module llsc_reservation_monitor_tb;
  localparam int unsigned AW = 64;
  localparam int unsigned DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_v = 0, sc_v = 0, snp_v = 0, irq = 0, exc = 0;
  logic [AW-1:0] ll_a = '0, sc_a = '0, snp_a = '0;
  logic [DW-1:0] sc_d = '0;
  logic mem_we, sc_done, sc_ok;
  logic [AW-1:0] mem_a;
  logic [DW-1:0] mem_d;

  int errors = 0;
  int checks = 0;
  logic exp_ok = 1'b0;

  always #2 clk = ~clk;

  llsc_reservation_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ll_valid_i(ll_v), .ll_addr_i(ll_a),
    .sc_valid_i(sc_v), .sc_addr_i(sc_a), .sc_data_i(sc_d),
    .snoop_valid_i(snp_v), .snoop_addr_i(snp_a),
    .irq_i(irq), .exc_i(exc),
    .mem_we_o(mem_we), .mem_addr_o(mem_a), .mem_data_o(mem_d),
    .sc_done_o(sc_done), .sc_ok_o(sc_ok)
  );

  typedef struct packed {
    logic ll; logic sc; logic snp; logic irq; logic exc;
    logic [15:0] lla; logic [15:0] sca; logic [15:0] sna;
    logic we;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 32;
  localparam row_t ROWS [NROWS] = '{
    '{1,0,0,0,0,16'h0100,16'h0000,16'h0000,0,4'd1},
    '{0,1,0,0,0,16'h0000,16'h0108,16'h0000,1,4'd1},  // R1 same block
    '{0,1,0,0,0,16'h0000,16'h0108,16'h0000,0,4'd6},  // R6 reservation consumed
    '{1,0,0,0,0,16'h0200,16'h0000,16'h0000,0,4'd2},
    '{0,0,0,1,0,16'h0000,16'h0000,16'h0000,0,4'd2},
    '{0,1,0,0,0,16'h0000,16'h0200,16'h0000,0,4'd2},  // R2 irq between
    '{1,0,0,0,0,16'h0300,16'h0000,16'h0000,0,4'd3},
    '{0,0,0,0,1,16'h0000,16'h0000,16'h0000,0,4'd3},
    '{0,1,0,0,0,16'h0000,16'h0300,16'h0000,0,4'd3},  // R3 exception between
    '{1,0,0,0,0,16'h0400,16'h0000,16'h0000,0,4'd4},
    '{0,0,1,0,0,16'h0000,16'h0000,16'h040C,0,4'd4},
    '{0,1,0,0,0,16'h0000,16'h0400,16'h0000,0,4'd4},  // R4 snoop inside
    '{1,0,0,0,0,16'h0500,16'h0000,16'h0000,0,4'd4},
    '{0,0,1,0,0,16'h0000,16'h0000,16'h0510,0,4'd4},
    '{0,1,0,0,0,16'h0000,16'h0504,16'h0000,1,4'd4},  // R4 snoop outside
    '{1,0,0,0,0,16'h0600,16'h0000,16'h0000,0,4'd5},
    '{0,1,0,0,0,16'h0000,16'h0610,16'h0000,0,4'd5},  // R5 other block
    '{1,0,0,0,0,16'h0700,16'h0000,16'h0000,0,4'd7},
    '{1,0,0,0,0,16'h0800,16'h0000,16'h0000,0,4'd7},
    '{0,1,0,0,0,16'h0000,16'h0700,16'h0000,0,4'd7},  // R7 old block
    '{1,0,0,0,0,16'h0900,16'h0000,16'h0000,0,4'd7},
    '{0,1,0,0,0,16'h0000,16'h090F,16'h0000,1,4'd7},  // R7 new block
    '{1,0,0,0,0,16'h0A00,16'h0000,16'h0000,0,4'd10},
    '{0,1,0,1,0,16'h0000,16'h0A00,16'h0000,0,4'd10}, // R10 irq with store
    '{1,0,0,1,0,16'h0B00,16'h0000,16'h0000,0,4'd10}, // R10 irq with load
    '{0,1,0,0,0,16'h0000,16'h0B00,16'h0000,0,4'd10},
    '{1,0,0,0,0,16'h0C00,16'h0000,16'h0000,0,4'd10},
    '{1,1,0,0,0,16'h0D00,16'h0C00,16'h0000,1,4'd10}, // R10 store+load same cycle
    '{0,1,0,0,0,16'h0000,16'h0D00,16'h0000,1,4'd10},
    '{1,0,1,0,0,16'h0E00,16'h0000,16'h0E08,0,4'd10}, // R10 snoop with load
    '{0,1,0,0,0,16'h0000,16'h0E00,16'h0000,0,4'd10},
    '{0,1,0,0,0,16'h0000,16'h0E00,16'h0000,0,4'd9}   // R9 nothing reserved
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic s, input logic sn, input logic i, input logic e,
                       input logic [AW-1:0] la, input logic [AW-1:0] sa, input logic [AW-1:0] na,
                       input logic [DW-1:0] d);
    @(negedge clk);
    ll_v = l; sc_v = s; snp_v = sn; irq = i; exc = e;
    ll_a = la; sc_a = sa; snp_a = na; sc_d = d;
    @(posedge clk);
    #1;
    ll_v = 0; sc_v = 0; snp_v = 0; irq = 0; exc = 0;
  endtask

  // checks outputs one cycle after a store-or-idle step
  task automatic expect_step(input string req, input logic s, input logic we,
                             input logic [AW-1:0] sa, input logic [DW-1:0] d);
    chk({req, " done"}, 64'(sc_done), 64'(s));
    chk({req, " we"}, 64'(mem_we), 64'(we));
    if (s) exp_ok = we;
    chk({req, " ok"}, 64'(sc_ok), 64'(exp_ok));   // R8 value or hold
    if (we) begin
      chk({req, " addr"}, mem_a, sa);
      chk({req, " data"}, mem_d, d);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #7;
    // R11 reset state
    chk("R11 we", 64'(mem_we), 64'd0);
    chk("R11 done", 64'(sc_done), 64'd0);
    chk("R11 ok", 64'(sc_ok), 64'd0);
    rst_n = 1'b1;

    // R9 store straight after reset
    drive(0, 1, 0, 0, 0, '0, 64'h40, '0, 64'h1);
    expect_step("R9", 1, 0, 64'h40, 64'h1);

    for (int r = 0; r < NROWS; r++) begin
      logic [DW-1:0] d;
      string tag;
      d = 64'hC0DE_0000_0000_0000 | 64'(r);
      tag = $sformatf("R%0d row%0d", ROWS[r].req, r);
      drive(ROWS[r].ll, ROWS[r].sc, ROWS[r].snp, ROWS[r].irq, ROWS[r].exc,
            64'(ROWS[r].lla), 64'(ROWS[r].sca), 64'(ROWS[r].sna), d);
      expect_step(tag, ROWS[r].sc, ROWS[r].we, 64'(ROWS[r].sca), d);
    end

    // R4 snoop address without valid does not cancel
    drive(1, 0, 0, 0, 0, 64'h120, '0, '0, '0);
    drive(0, 0, 0, 0, 0, '0, '0, 64'h120, '0);
    drive(0, 1, 0, 0, 0, '0, 64'h12C, '0, 64'hBEEF);
    expect_step("R4 idle snoop", 1, 1, 64'h12C, 64'hBEEF);

    // R1 full-width upper address bits
    drive(1, 0, 0, 0, 0, 64'hFFFF_0000_0000_1230, '0, '0, '0);
    drive(0, 1, 0, 0, 0, '0, 64'hFFFF_0000_0000_1238, '0, 64'h55);
    expect_step("R1 high addr", 1, 1, 64'hFFFF_0000_0000_1238, 64'h55);
    drive(1, 0, 0, 0, 0, 64'hFFFF_0000_0000_1230, '0, '0, '0);
    drive(0, 1, 0, 0, 0, '0, 64'h7FFF_0000_0000_1238, '0, 64'h56);
    expect_step("R5 high addr", 1, 0, 64'h7FFF_0000_0000_1238, 64'h56);

    // R11 reset drops a live reservation
    drive(1, 0, 0, 0, 0, 64'hF00, '0, '0, '0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 ok after reset", 64'(sc_ok), 64'd0);
    exp_ok = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 1, 0, 0, 0, '0, 64'hF00, '0, 64'h77);
    expect_step("R11 reservation cleared", 1, 0, 64'hF00, 64'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule